// File: doc/BRIEF.md
# One-hot run-of-ones detector

This block is a small Mealy state machine that watches a serial bit stream and reports when a run of ones, started after a zero, has grown long enough. Each state owns one flip-flop, so exactly one bit of the state register is set at any time. Each bit's next value is a short product term read off the transition table. The output is the AND of the input with the last state bit.

A zero on the input always sends the machine to the second state. Each further one moves it one state along the chain until it reaches the last state, where it stays while ones keep arriving. From the first state, ones leave the machine where it is. A synchronous `init` input puts the machine in the first state. The parameter `NS` sets the chain length (at least 4, default 5). With the default, the output goes high on the fourth consecutive one after a zero.

Top module: `onehot_seq_det`

## Requirements
- R1: When `init` is 1 at a rising clock edge, the state becomes state 1 (`state` = 1, i.e. only bit 0 set), whatever the value of `din`.
- R2: At every clock after the first `init`, exactly one bit of `state` is 1. Bit k-1 stands for state k.
- R3: When `init` is 0 and `din` is 0 at a rising edge, the next state is state 2 (only bit 1 set), from any state.
- R4: When `init` is 0 and `din` is 1 in state 1, the machine stays in state 1.
- R5: When `init` is 0 and `din` is 1 in state k, for 2 <= k < NS, the next state is state k+1.
- R6: When `init` is 0 and `din` is 1 in state NS, the machine stays in state NS.
- R7: `dout` is 1 in the same cycle, with no register on the path, exactly when the machine is in state NS and `din` is 1.
- R8: After a zero and with no `init` in between, `dout` is 1 on the (NS-1)-th consecutive one and on every later one of the same run. It is 0 on the earlier ones of the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| init | input | 1 | Synchronous start: load state 1 |
| din | input | 1 | Serial input bit |
| state | output | NS | One-hot state register, bit k-1 for state k |
| dout | output | 1 | Mealy output, high on a qualifying one |

## Verification
The bench builds the default five-state chain. It starts from `init` and drives every 8-bit input word, which covers all routes through the chain, including long stays in the first and last states. It also covers runs of ones that start before any zero has been seen. With eight steps per word, every state is entered from every predecessor the table allows, and every state sees both input values. The bench also asserts `init` in the middle of runs, with both input values, to show that `init` overrides the input.

// File: rtl/onehot_seq_det.sv
module onehot_seq_det #(
  parameter int NS = 5
) (
  input  logic          clk,
  input  logic          init,
  input  logic          din,
  output logic [NS-1:0] state,
  output logic          dout
);
  localparam int LAST = NS - 1;

  logic [NS-1:0] nxt;

  assign nxt[0]    = din & state[0];
  assign nxt[1]    = ~din;
  assign nxt[LAST] = din & (state[LAST-1] | state[LAST]);

  for (genvar k = 2; k < LAST; k++) begin : g_mid
    assign nxt[k] = din & state[k-1];
  end

  always_ff @(posedge clk) begin
    if (init) state <= NS'(1);
    else      state <= nxt;
  end

  assign dout = din & state[LAST];
endmodule

// File: rtl/onehot_seq_det_chk.sv
module onehot_seq_det_chk #(
  parameter int NS = 5
) (
  input logic          clk,
  input logic          init,
  input logic          din,
  input logic [NS-1:0] state,
  input logic          dout
);
  localparam int LAST = NS - 1;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | init;

  // R1
  init_load_chk: assert property (@(posedge clk) disable iff (!armed)
    init |=> (state == NS'(1)));

  // R2
  onehot_chk: assert property (@(posedge clk) disable iff (!armed)
    $countones(state) == 1);

  // R3
  zero_back_chk: assert property (@(posedge clk) disable iff (!armed)
    (!init && !din) |=> (state == NS'(2)));

  // R4
  hold_first_chk: assert property (@(posedge clk) disable iff (!armed)
    (!init && din && state[0]) |=> state[0]);

  // R5
  reach_last_chk: assert property (@(posedge clk) disable iff (!armed)
    (!init && din && state[LAST-1]) |=> state[LAST]);

  // R6
  hold_last_chk: assert property (@(posedge clk) disable iff (!armed)
    (!init && dout) |=> state[LAST]);

  // R7
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!armed)
    dout |-> din);
endmodule

bind onehot_seq_det onehot_seq_det_chk #(.NS(NS)) u_chk (
  .clk(clk), .init(init), .din(din), .state(state), .dout(dout)
);

// File: tb/sim_onehot_seq_det.sv
module sim_onehot_seq_det;
  localparam int NS = 5;

  logic clk = 1'b0;
  logic init = 1'b0;
  logic din = 1'b0;
  logic [NS-1:0] state;
  logic dout;

  int total = 0;
  int bad = 0;
  int ms = 1;
  bit seen0 = 0;
  int run = 0;
  bit done = 0;

  always #10 clk = ~clk;

  onehot_seq_det #(.NS(NS)) u0 (
    .clk(clk), .init(init), .din(din), .state(state), .dout(dout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit i, input bit x);
    string tag;
    logic [NS-1:0] es;
    @(negedge clk);
    init = i;
    din  = x;
    #5;
    if (!i) begin
      chk("R7", 32'(dout), 32'(x && ms == NS));
      chk("R8", 32'(dout), 32'(x && seen0 && run + 1 >= NS - 1));
    end
    if (i)             begin tag = "R1"; ms = 1; seen0 = 0; run = 0; end
    else if (!x)       begin tag = "R3"; ms = 2; seen0 = 1; run = 0; end
    else if (ms == 1)  begin tag = "R4"; run++; end
    else if (ms == NS) begin tag = "R6"; run++; end
    else               begin tag = "R5"; ms++; run++; end
    @(posedge clk);
    #2;
    es = '0;
    es[ms-1] = 1'b1;
    chk(tag, 32'(state), 32'(es));
    chk("R2", 32'($countones(state)), 32'd1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state through init, with din high
    step(1, 1);
    for (int w = 0; w < 256; w++) begin
      step(1, w[0]);
      for (int b = 0; b < 8; b++) step(0, w[b]);
    end
    // R1 init overrides a run in the last state, both input values
    step(0, 0);
    for (int k = 0; k < 5; k++) step(0, 1);
    step(1, 1);
    step(0, 1);
    step(0, 0);
    step(0, 1);
    step(1, 0);
    step(0, 1);
    // R8 long run: high on every one from the fourth on
    step(0, 0);
    for (int k = 0; k < 12; k++) step(0, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule